// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block is a multi-cycle integer multiply and divide engine that sits beside an integer core. A command carries a 6-bit function code and two 32-bit source operands. Multiply and divide commands start a computation that iterates one bit per cycle: shift-and-add for the product, restoring subtraction for the quotient. Results land in a dedicated pair of 32-bit result registers, HI and LO, and not in the general register file.

The core reads HI or LO back with separate move-from commands, and it can load either register directly with move-to commands. While an operation runs, the unit reports busy. A read issued during that time returns the previous contents and raises a stall indication, so the core can hold its pipeline. Signed operations work on magnitudes and correct the sign at the end. Division by zero ends in the normal cycle count with a fixed result.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO hold zero, and busy_o and done_o are low.
- R2: Function 0x18 multiplies the operands as two's complement numbers and writes the 64-bit product, upper half to HI and lower half to LO.
- R3: Function 0x19 multiplies the operands as unsigned magnitudes, with the same HI/LO placement as R2.
- R4: Function 0x1A divides src_a by src_b as two's complement numbers. The quotient is truncated toward zero and goes to LO. The remainder carries the sign of the dividend and goes to HI. A most-negative dividend divided by -1 yields 0x80000000 in LO and zero in HI.
- R5: Function 0x1B divides as unsigned magnitudes, with the quotient in LO and the remainder in HI.
- R6: An accepted multiply or divide keeps busy_o high for exactly 32 cycles. HI and LO are updated at the edge where busy_o falls, and done_o is high for the single cycle after that edge.
- R7: Division by zero, signed or unsigned, completes in the normal time and leaves all ones in LO and the raw src_a value in HI.
- R8: A command with function 0x10 presents HI on rd_data_o, and one with 0x12 presents LO, in the same cycle, without a clock edge.
- R9: Function 0x11 loads src_a into HI and function 0x13 loads src_a into LO at the next edge. Neither raises busy_o.
- R10: While busy_o is high, multiply, divide and move-to commands are ignored. HI and LO end up holding the result of the running operation only.
- R11: A read command issued while busy_o is high returns the pre-operation HI or LO value and raises stall_o in that cycle. A read issued while idle keeps stall_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_funct_i | input | 6 | Function code of the command |
| src_a_i | input | 32 | First operand (dividend, multiplier, move-to data) |
| src_b_i | input | 32 | Second operand (divisor, multiplicand) |
| busy_o | output | 1 | An iterative operation is in progress |
| done_o | output | 1 | One-cycle pulse after HI/LO are updated |
| rd_data_o | output | 32 | HI or LO for a read command, zero otherwise |
| stall_o | output | 1 | Read command issued while busy |

## Verification
Multiplies are tried with mixed-sign, both-negative, most-negative-squared and all-ones operands. These cases tell a correct final negation apart from a wrong or missing one, and they show whether the upper half keeps the carries of the shift-and-add loop. Divides cover all four sign combinations of a small pair, which separates quotient negation from remainder-sign handling. They also cover the most-negative-by-minus-one edge, an unsigned divide with a dividend smaller than the divisor, and a divide by zero with a negative dividend, which tells the fixed zero-divisor result apart from a sign-corrected iteration result. A command storm during a running multiply shows that starts and writes are dropped while reads stall and return the old contents.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  localparam logic [5:0] FN_RD_HI = 6'h10;
  localparam logic [5:0] FN_WR_HI = 6'h11;
  localparam logic [5:0] FN_RD_LO = 6'h12;
  localparam logic [5:0] FN_WR_LO = 6'h13;
  localparam logic [5:0] FN_MUL_S = 6'h18;
  localparam logic [5:0] FN_MUL_U = 6'h19;
  localparam logic [5:0] FN_DIV_S = 6'h1A;
  localparam logic [5:0] FN_DIV_U = 6'h1B;

  typedef enum logic {
    ENG_MUL = 1'b0,
    ENG_DIV = 1'b1
  } eng_mode_e;

  typedef struct packed {
    logic      run;    // starts the iterative engine
    eng_mode_e mode;
    logic      sgn;    // two's complement operands
    logic      rd_hi;
    logic      rd_lo;
    logic      wr_hi;
    logic      wr_lo;
  } cmd_dec_t;
endpackage

// File: rtl/mdu_decode.sv
`timescale 1ns/1ps
module mdu_decode
  import mdu_pkg::*;
(
  input  logic [5:0] funct,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    unique case (funct)
      FN_MUL_S: begin dec.run = 1'b1; dec.mode = ENG_MUL; dec.sgn = 1'b1; end
      FN_MUL_U: begin dec.run = 1'b1; dec.mode = ENG_MUL; end
      FN_DIV_S: begin dec.run = 1'b1; dec.mode = ENG_DIV; dec.sgn = 1'b1; end
      FN_DIV_U: begin dec.run = 1'b1; dec.mode = ENG_DIV; end
      FN_RD_HI: dec.rd_hi = 1'b1;
      FN_RD_LO: dec.rd_lo = 1'b1;
      FN_WR_HI: dec.wr_hi = 1'b1;
      FN_WR_LO: dec.wr_lo = 1'b1;
      default:  dec = '0;
    endcase
  end
endmodule

// File: rtl/mdu_prep.sv
`timescale 1ns/1ps
// Turns operands into magnitudes and records the sign corrections needed later.
module mdu_prep #(
  parameter int W = 32
) (
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         neg_main,  // product / quotient must be negated
  output logic         neg_rem    // remainder must be negated
);
  function automatic logic [W-1:0] magnitude(logic [W-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic a_neg, b_neg;

  assign a_neg    = sgn & a[W-1];
  assign b_neg    = sgn & b[W-1];
  assign a_mag    = magnitude(a, a_neg);
  assign b_mag    = magnitude(b, b_neg);
  assign neg_main = a_neg ^ b_neg;
  assign neg_rem  = a_neg;
endmodule

// File: rtl/mdu_engine.sv
`timescale 1ns/1ps
// One-bit-per-cycle datapath shared by multiply and divide.
// Accumulator layout: upper half = partial product / partial remainder,
// lower half = multiplier bits / dividend bits shifting into quotient.
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  eng_mode_e    mode,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         last,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  localparam int CW = $clog2(W + 1);
  localparam int AW = 2 * W;

  function automatic logic [AW-1:0] mul_step(logic [AW-1:0] acc, logic [W-1:0] mc);
    logic [W:0] sum;
    sum = {1'b0, acc[AW-1:W]} + (acc[0] ? {1'b0, mc} : {(W+1){1'b0}});
    return {sum, acc[W-1:1]};
  endfunction

  function automatic logic [AW-1:0] div_step(logic [AW-1:0] acc, logic [W-1:0] dv);
    logic [W:0] shifted, trial;
    logic       qbit;
    shifted = {acc[AW-1:W], acc[W-1]};
    trial   = shifted - {1'b0, dv};
    qbit    = ~trial[W];
    return {(qbit ? trial[W-1:0] : shifted[W-1:0]), acc[W-2:0], qbit};
  endfunction

  eng_mode_e       mode_q;
  logic [AW-1:0]   acc_q;
  logic [W-1:0]    opnd_q;
  logic [CW-1:0]   cnt_q;
  logic [AW-1:0]   step_w;

  assign step_w = (mode_q == ENG_DIV) ? div_step(acc_q, opnd_q) : mul_step(acc_q, opnd_q);
  assign last   = run && (cnt_q == CW'(W - 1));
  assign nxt_hi = step_w[AW-1:W];
  assign nxt_lo = step_w[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ENG_MUL;
      acc_q  <= '0;
      opnd_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      mode_q <= mode;
      acc_q  <= {{W{1'b0}}, a_mag};
      opnd_q <= b_mag;
      cnt_q  <= '0;
    end else if (run) begin
      acc_q  <= step_w;
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdu_fix.sv
`timescale 1ns/1ps
// Applies sign correction and the zero-divisor override to the raw engine result.
module mdu_fix
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  eng_mode_e    mode,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic         div_zero,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  function automatic logic [2*W-1:0] neg_wide(logic [2*W-1:0] v, logic en);
    return en ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] neg_word(logic [W-1:0] v, logic en);
    return en ? (~v + 1'b1) : v;
  endfunction

  logic [2*W-1:0] prod_w;

  assign prod_w = neg_wide({raw_hi, raw_lo}, neg_main);

  always_comb begin
    if (mode == ENG_MUL) begin
      res_hi = prod_w[2*W-1:W];
      res_lo = prod_w[W-1:0];
    end else if (div_zero) begin
      res_hi = dividend;
      res_lo = '1;
    end else begin
      res_hi = neg_word(raw_hi, neg_rem);
      res_lo = neg_word(raw_lo, neg_main);
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [5:0]       cmd_funct_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             stall_o
);
  cmd_dec_t         dec_w;
  logic [WIDTH-1:0] a_mag_w, b_mag_w;
  logic             neg_main_w, neg_rem_w;
  logic             last_w;
  logic [WIDTH-1:0] raw_hi_w, raw_lo_w, res_hi_w, res_lo_w;

  logic             busy_q, done_q;
  logic [WIDTH-1:0] hi_q, lo_q;
  eng_mode_e        mode_q;
  logic             neg_main_q, neg_rem_q, div_zero_q;
  logic [WIDTH-1:0] dividend_q;

  // named internal events
  logic accept_w;   // multiply/divide taken
  logic finish_w;   // final iteration, HI/LO written
  logic wr_hi_w, wr_lo_w;

  mdu_decode u_dec (
    .funct (cmd_funct_i),
    .dec   (dec_w)
  );

  mdu_prep #(.W(WIDTH)) u_prep (
    .sgn      (dec_w.sgn),
    .a        (src_a_i),
    .b        (src_b_i),
    .a_mag    (a_mag_w),
    .b_mag    (b_mag_w),
    .neg_main (neg_main_w),
    .neg_rem  (neg_rem_w)
  );

  assign accept_w = cmd_valid_i && !busy_q && dec_w.run;
  assign wr_hi_w  = cmd_valid_i && !busy_q && dec_w.wr_hi;
  assign wr_lo_w  = cmd_valid_i && !busy_q && dec_w.wr_lo;
  assign finish_w = last_w;

  mdu_engine #(.W(WIDTH)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_w),
    .run    (busy_q),
    .mode   (dec_w.mode),
    .a_mag  (a_mag_w),
    .b_mag  (b_mag_w),
    .last   (last_w),
    .nxt_hi (raw_hi_w),
    .nxt_lo (raw_lo_w)
  );

  mdu_fix #(.W(WIDTH)) u_fix (
    .mode     (mode_q),
    .neg_main (neg_main_q),
    .neg_rem  (neg_rem_q),
    .div_zero (div_zero_q),
    .dividend (dividend_q),
    .raw_hi   (raw_hi_w),
    .raw_lo   (raw_lo_w),
    .res_hi   (res_hi_w),
    .res_lo   (res_lo_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      mode_q     <= ENG_MUL;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      div_zero_q <= 1'b0;
      dividend_q <= '0;
    end else begin
      done_q <= finish_w;
      if (accept_w) begin
        busy_q     <= 1'b1;
        mode_q     <= dec_w.mode;
        neg_main_q <= neg_main_w;
        neg_rem_q  <= neg_rem_w;
        div_zero_q <= (src_b_i == '0);
        dividend_q <= src_a_i;
      end else if (finish_w) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish_w) begin
      hi_q <= res_hi_w;
      lo_q <= res_lo_w;
    end else begin
      if (wr_hi_w) hi_q <= src_a_i;
      if (wr_lo_w) lo_q <= src_a_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (cmd_valid_i && dec_w.rd_hi) rd_data_o = hi_q;
    if (cmd_valid_i && dec_w.rd_lo) rd_data_o = lo_q;
  end

  assign stall_o = cmd_valid_i && busy_q && (dec_w.rd_hi || dec_w.rd_lo);
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mdu_checker.sv
`timescale 1ns/1ps
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [5:0]   funct,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         busy,
  input logic         done,
  input logic         stall,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         accept_w,
  input logic         finish_w
);
  logic [15:0]  busy_cnt;
  logic         zdiv_q;
  logic [W-1:0] zdvd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      zdiv_q   <= 1'b0;
      zdvd_q   <= '0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 16'd1 : 16'd0;
      if (accept_w) begin
        zdiv_q <= (funct[5:1] == 5'b01101) && (src_b == '0);
        zdvd_q <= src_a;
      end
    end
  end

  p_busy_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == 16'(W));

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_finish_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> done && !busy);

  p_hilo_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(hi_q) && $stable(lo_q));

  p_read_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy && (funct == 6'h10) |-> stall && rd_data == hi_q);

  p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && zdiv_q |-> lo_q == '1 && hi_q == zdvd_q);

  p_write_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && !busy && funct == 6'h11) |-> hi_q == $past(src_a) && !busy);
endmodule

bind muldiv_hilo mdu_checker #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid_i),
  .funct     (cmd_funct_i),
  .src_a     (src_a_i),
  .src_b     (src_b_i),
  .busy      (busy_o),
  .done      (done_o),
  .stall     (stall_o),
  .rd_data   (rd_data_o),
  .hi_q      (hi_q),
  .lo_q      (lo_q),
  .accept_w  (accept_w),
  .finish_w  (finish_w)
);

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/1ps
module sim_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  funct = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, done, stall;
  logic [31:0] rd_data;

  int n_run = 0, n_fail = 0;
  logic [31:0] mh = '0, ml = '0;   // bench model of HI/LO

  typedef struct {
    logic [31:0] val;
    logic        stl;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  muldiv_hilo u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_funct_i(funct),
    .src_a_i(src_a), .src_b_i(src_b), .busy_o(busy), .done_o(done),
    .rd_data_o(rd_data), .stall_o(stall)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    #5;
    if (rst_n && cmd_valid && (funct == 6'h10 || funct == 6'h12)) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", rd_data, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_data == e.val, e.tag, rd_data, e.val);
        chk(stall == e.stl, {e.tag, " stall"}, stall, e.stl);
      end
    end
  end

  task automatic send(logic v, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmd_valid = v; funct = f; src_a = a; src_b = b;
  endtask

  task automatic rd(logic [5:0] f, logic [31:0] e, logic s, string tag);
    exp_t it;
    it.val = e; it.stl = s; it.tag = tag;
    sb_q.push_back(it);
    send(1'b1, f, 32'h0, 32'h0);
  endtask

  task automatic model(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    longint p;
    longint unsigned pu;
    longint sa, sbv;
    case (f)
      6'h18: begin p = longint'($signed(a)) * longint'($signed(b)); mh = p[63:32]; ml = p[31:0]; end
      6'h19: begin pu = {32'h0, a} * {32'h0, b}; mh = pu[63:32]; ml = pu[31:0]; end
      6'h1A: begin
        if (b == 0) begin ml = '1; mh = a; end
        else begin
          sa = longint'($signed(a)); sbv = longint'($signed(b));
          p = sa / sbv; ml = p[31:0];
          p = sa % sbv; mh = p[31:0];
        end
      end
      6'h1B: begin
        if (b == 0) begin ml = '1; mh = a; end
        else begin ml = a / b; mh = a % b; end
      end
      default: ;
    endcase
  endtask

  task automatic run_op(logic [5:0] f, logic [31:0] a, logic [31:0] b, string tag);
    int cnt;
    model(f, a, b);
    send(1'b1, f, a, b);
    send(1'b0, 6'h0, 32'h0, 32'h0);
    cnt = 0;
    forever begin
      #5;
      if (!busy) break;
      cnt++;
      if (cnt > 100) break;
      @(negedge clk);
    end
    chk(cnt == 32, "R6 busy cycles", cnt, 32);
    chk(done == 1'b1, "R6 done pulse", done, 1);
    #20;
    chk(done == 1'b0, "R6 done single", done, 0);
    rd(6'h10, mh, 1'b0, {tag, " HI"});
    rd(6'h12, ml, 1'b0, {tag, " LO"});
    send(1'b0, 6'h0, 32'h0, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);
    rd(6'h10, 32'h0, 1'b0, "R1 HI reset");
    rd(6'h12, 32'h0, 1'b0, "R8 R1 LO reset");
    send(1'b0, 6'h0, 32'h0, 32'h0);

    // R2 signed multiply
    run_op(6'h18, 32'd7, -32'sd3, "R2 7*-3");
    run_op(6'h18, -32'sd5, -32'sd6, "R2 -5*-6");
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R2 minneg squared");
    run_op(6'h18, 32'h1234_5678, 32'h9ABC_DEF0, "R2 mixed");
    // R3 unsigned multiply
    run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones squared");
    run_op(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, "R3 mixed");
    // R4 signed divide
    run_op(6'h1A, 32'd100, 32'd7, "R4 100/7");
    run_op(6'h1A, -32'sd100, 32'd7, "R4 -100/7");
    run_op(6'h1A, 32'd100, -32'sd7, "R4 100/-7");
    run_op(6'h1A, -32'sd100, -32'sd7, "R4 -100/-7");
    run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R4 minneg/-1");
    // R5 unsigned divide
    run_op(6'h1B, 32'hFFFF_FFFF, 32'd3, "R5 ones/3");
    run_op(6'h1B, 32'h8000_0000, 32'hFFFF_FFFF, "R5 small/large");
    // R7 divide by zero
    run_op(6'h1A, -32'sd77, 32'd0, "R7 signed by zero");
    run_op(6'h1B, 32'hCAFE_0001, 32'd0, "R7 unsigned by zero");

    // R9 move-to writes
    send(1'b1, 6'h11, 32'hA5A5_0001, 32'h0);
    send(1'b1, 6'h13, 32'h5A5A_0002, 32'h0);
    send(1'b0, 6'h0, 32'h0, 32'h0);
    #5;
    chk(busy == 1'b0, "R9 no busy on write", busy, 0);
    mh = 32'hA5A5_0001; ml = 32'h5A5A_0002;
    rd(6'h10, mh, 1'b0, "R9 R8 HI written");
    rd(6'h12, ml, 1'b0, "R9 R8 LO written");
    send(1'b0, 6'h0, 32'h0, 32'h0);

    // R10 / R11 commands during a running multiply
    begin
      logic [31:0] old_hi, old_lo;
      old_hi = mh; old_lo = ml;
      model(6'h18, 32'd1000, -32'sd2);
      send(1'b1, 6'h18, 32'd1000, -32'sd2);
      send(1'b1, 6'h1B, 32'd5, 32'd6);
      rd(6'h10, old_hi, 1'b1, "R11 HI while busy");
      rd(6'h12, old_lo, 1'b1, "R11 LO while busy");
      send(1'b1, 6'h11, 32'hDEAD_BEEF, 32'h0);
      send(1'b1, 6'h13, 32'hDEAD_BEEF, 32'h0);
      send(1'b0, 6'h0, 32'h0, 32'h0);
      #5;
      while (busy) #20;
      chk(done == 1'b1, "R10 done after storm", done, 1);
      rd(6'h10, mh, 1'b0, "R10 HI keeps running result");
      rd(6'h12, ml, 1'b0, "R10 LO keeps running result");
      send(1'b0, 6'h0, 32'h0, 32'h0);
      #5;
      chk(busy == 1'b0, "R10 ignored start did not run", busy, 0);
    end

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule